// File: doc/BRIEF.md
# I/O Wait-State Trap Bridge

This block lets a slow service agent answer a fast CPU's I/O bus cycles. When the CPU pulls its active-low I/O request line low, the bridge drops the CPU's active-low wait line, which stalls the CPU. It then captures the port address, the direction and, for writes, the data byte. Next it raises a request toward the service agent. The agent may take any number of cycles. When it acknowledges, the wait line goes high again. On a read, the bridge also drives the byte the agent returned until the CPU ends the cycle. The wait line acts as a set/reset latch: the start of an I/O cycle clears it, and completion sets it.

Port numbers stand for firmware function numbers. Two of them are handled specially. A write to the console port never reaches the service agent. Its byte goes to a valid/ready transmit handshake instead, and wait stays low until the transmitter takes the byte. A write to the reload port is serviced as usual and also gives a one-cycle reload pulse. The block also produces the CPU clock at half the system clock rate. The bus strobes pass through a configurable synchronizer before the control logic uses them.

Top module: `iowait_bridge`

## Requirements
- R1: After reset, wait_n is 1, cpu_clk is 0, and svc_req, tx_valid, data_oe and reload_req are all 0.
- R2: cpu_clk toggles on every system clock edge after reset, so it runs at half the system clock frequency.
- R3: Within SYNC_STAGES+2 clocks of iorq_n going low, wait_n goes low. It stays low while a service or transmit request is outstanding.
- R4: For any cycle except a console write, svc_req rises with svc_port equal to the bus address. svc_write is 1 when wr_n was low and 0 when rd_n was low. On writes, svc_wdata holds the data byte. All of these stay stable until svc_ack.
- R5: A svc_ack seen while svc_req is high sets wait_n to 1 at the next clock and drops svc_req.
- R6: On a read, the byte on svc_rdata at acknowledge time appears on data_out with data_oe = 1 from the release of wait until iorq_n returns high. On writes and when idle, data_oe is 0.
- R7: One bus cycle gives at most one request. After completion, no new svc_req or tx_valid appears while iorq_n stays low.
- R8: A write to port CONSOLE_PORT (default 4) raises tx_valid with tx_data equal to the data byte and never raises svc_req. tx_valid and tx_data hold, and wait_n stays low, until tx_ready is seen. wait_n is 1 on the clock after that.
- R9: A write to port RELOAD_PORT (default 1) gives reload_req = 1 for exactly one clock, on the same clock that svc_req first rises. It is serviced like any other port.
- R10: A read from the console port goes to the service side like any other read, and tx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk | output | 1 | CPU clock, system clock divided by two |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| addr | input | ADDR_W | Port address from the CPU |
| data_in | input | DATA_W | Write data from the CPU |
| data_out | output | DATA_W | Read data toward the CPU |
| data_oe | output | 1 | High when data_out must drive the CPU data bus |
| wait_n | output | 1 | CPU wait line, active low |
| svc_req | output | 1 | Request to the service agent |
| svc_write | output | 1 | 1 for a write cycle, 0 for a read |
| svc_port | output | ADDR_W | Captured port address |
| svc_wdata | output | DATA_W | Captured write byte |
| svc_ack | input | 1 | Service agent completion |
| svc_rdata | input | DATA_W | Byte returned for reads, sampled with svc_ack |
| reload_req | output | 1 | One-cycle reload pulse on a reload-port write |
| tx_valid | output | 1 | Console byte offered to the transmitter |
| tx_data | output | DATA_W | Console byte |
| tx_ready | input | 1 | Transmitter accepts tx_data |

## Verification
The bench runs reads and writes to ordinary ports, to the console port and to the reload port. Service and transmitter delays range from zero to several cycles, so an early release of wait shows up as a wrong value. Console writes check that the byte goes only to the transmit path, and console reads check that reads are not sent there. Holding iorq_n low for several cycles after completion checks for a duplicate request. Comparing reads with writes checks when data_oe is driven and when it is released.

// File: rtl/iowb_pkg.sv
package iowb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_SVC  = 3'd2,
        ST_TX   = 3'd3,
        ST_DONE = 3'd4
    } iowb_state_e;

endpackage

// File: rtl/iowb_sync.sv
module iowb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
                end else begin
                    stage_q[0] <= async_i;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign sync_o = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/iowb_clkdiv.sv
module iowb_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic clk_half
);
    logic half_d, half_q;

    always_comb begin
        half_d = ~half_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
    end

    assign clk_half = half_q;
endmodule

// File: rtl/iowb_ctrl.sv
module iowb_ctrl
    import iowb_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int CONSOLE_PORT = 4,
    parameter int RELOAD_PORT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iorq_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              svc_ack,
    input  logic [DATA_W-1:0] svc_rdata,
    input  logic              tx_ready,
    output logic              wait_n,
    output logic              svc_req,
    output logic              svc_write,
    output logic [ADDR_W-1:0] svc_port,
    output logic [DATA_W-1:0] svc_wdata,
    output logic              reload_req,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam logic [ADDR_W-1:0] CON_A = ADDR_W'(CONSOLE_PORT);
    localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(RELOAD_PORT);

    typedef struct packed {
        iowb_state_e       state;
        logic              wait_n;
        logic              is_wr;
        logic              drive;
        logic              reload;
        logic [ADDR_W-1:0] port;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  wr_hit, rd_hit;

    always_comb begin
        wr_hit = ~wr_s;
        rd_hit = ~rd_s;
        ctl_d  = ctl_q;
        ctl_d.reload = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (!iorq_s) begin
                    ctl_d.wait_n = 1'b0;
                    ctl_d.state  = ST_ARM;
                end
            end
            ST_ARM: begin
                if (iorq_s) begin
                    ctl_d.wait_n = 1'b1;
                    ctl_d.state  = ST_IDLE;
                end else if (wr_hit || rd_hit) begin
                    ctl_d.port   = addr;
                    ctl_d.is_wr  = wr_hit;
                    ctl_d.wdata  = wr_hit ? data_in : '0;
                    ctl_d.reload = wr_hit && (addr == RLD_A);
                    ctl_d.state  = (wr_hit && (addr == CON_A)) ? ST_TX : ST_SVC;
                end
            end
            ST_SVC: begin
                if (svc_ack) begin
                    ctl_d.wait_n = 1'b1;
                    ctl_d.state  = ST_DONE;
                    if (!ctl_q.is_wr) begin
                        ctl_d.rdata = svc_rdata;
                        ctl_d.drive = 1'b1;
                    end
                end
            end
            ST_TX: begin
                if (tx_ready) begin
                    ctl_d.wait_n = 1'b1;
                    ctl_d.state  = ST_DONE;
                end
            end
            ST_DONE: begin
                if (iorq_s) begin
                    ctl_d.drive = 1'b0;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.state  <= ST_IDLE;
            ctl_q.wait_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wait_n     = ctl_q.wait_n;
    assign svc_req    = (ctl_q.state == ST_SVC);
    assign svc_write  = ctl_q.is_wr;
    assign svc_port   = ctl_q.port;
    assign svc_wdata  = ctl_q.wdata;
    assign reload_req = ctl_q.reload;
    assign tx_valid   = (ctl_q.state == ST_TX);
    assign tx_data    = ctl_q.wdata;
    assign data_out   = ctl_q.rdata;
    assign data_oe    = ctl_q.drive;
endmodule

// File: rtl/iowait_bridge.sv
module iowait_bridge #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int CONSOLE_PORT = 4,
    parameter int RELOAD_PORT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cpu_clk,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              wait_n,
    output logic              svc_req,
    output logic              svc_write,
    output logic [ADDR_W-1:0] svc_port,
    output logic [DATA_W-1:0] svc_wdata,
    input  logic              svc_ack,
    input  logic [DATA_W-1:0] svc_rdata,
    output logic              reload_req,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready
);
    localparam int STROBES = 3;

    logic [STROBES-1:0] strobe_s;

    iowb_sync #(.WIDTH(STROBES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({iorq_n, rd_n, wr_n}),
        .sync_o  (strobe_s)
    );

    iowb_clkdiv u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_half (cpu_clk)
    );

    iowb_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CONSOLE_PORT(CONSOLE_PORT), .RELOAD_PORT(RELOAD_PORT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .iorq_s     (strobe_s[2]),
        .rd_s       (strobe_s[1]),
        .wr_s       (strobe_s[0]),
        .addr       (addr),
        .data_in    (data_in),
        .svc_ack    (svc_ack),
        .svc_rdata  (svc_rdata),
        .tx_ready   (tx_ready),
        .wait_n     (wait_n),
        .svc_req    (svc_req),
        .svc_write  (svc_write),
        .svc_port   (svc_port),
        .svc_wdata  (svc_wdata),
        .reload_req (reload_req),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );
endmodule

// File: rtl/iowb_chk.sv
module iowb_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_clk,
    input logic              wait_n,
    input logic              data_oe,
    input logic              svc_req,
    input logic              svc_ack,
    input logic [ADDR_W-1:0] svc_port,
    input logic [DATA_W-1:0] svc_wdata,
    input logic              reload_req,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data
);
    logic seen_edge_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge_q <= 1'b0;
        else        seen_edge_q <= 1'b1;
    end

    // R2
    clk_half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge_q |-> (cpu_clk != $past(cpu_clk)));

    // R3
    wait_held_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> !wait_n);

    // R8
    wait_held_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !wait_n);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !svc_ack) |=> (svc_req && $stable(svc_port) && $stable(svc_wdata)));

    // R5
    release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && svc_ack) |=> (wait_n && !svc_req));

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6
    drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> wait_n);

    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({svc_req, tx_valid}));

    // R9
    reload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> !reload_req);
endmodule

bind iowait_bridge iowb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_clk    (cpu_clk),
    .wait_n     (wait_n),
    .data_oe    (data_oe),
    .svc_req    (svc_req),
    .svc_ack    (svc_ack),
    .svc_port   (svc_port),
    .svc_wdata  (svc_wdata),
    .reload_req (reload_req),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data)
);

// File: tb/iowait_bridge_tb.sv
module iowait_bridge_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_clk, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0, data_out, svc_wdata, svc_rdata = '0, tx_data;
    logic data_oe, wait_n, svc_req, svc_write, svc_ack = 1'b0;
    logic [AW-1:0] svc_port;
    logic reload_req, tx_valid, tx_ready = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    iowait_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .wait_n(wait_n),
        .svc_req(svc_req), .svc_write(svc_write), .svc_port(svc_port),
        .svc_wdata(svc_wdata), .svc_ack(svc_ack), .svc_rdata(svc_rdata),
        .reload_req(reload_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    function automatic bit goes_to_tx(bit is_wr, logic [AW-1:0] port);
        return is_wr && (port == AW'(4));
    endfunction

    function automatic bit is_reload(bit is_wr, logic [AW-1:0] port);
        return is_wr && (port == AW'(1));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic io_cycle(bit is_wr, logic [AW-1:0] port, logic [DW-1:0] wbyte,
                            int delay, logic [DW-1:0] rbyte);
        int  n;
        bit  ok;
        bit  to_tx = goes_to_tx(is_wr, port);
        @(negedge clk);
        addr = port; data_in = wbyte; iorq_n = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        // R3: wait falls within SYNC+2 clocks
        n = 0;
        while (wait_n && n < SYNC + 3) begin @(negedge clk); n++; end
        check(!wait_n && n <= SYNC + 2, "R3", "wait_n fall latency", n, SYNC + 2);
        n = 0;
        while (!(svc_req || tx_valid) && n < 8) begin @(negedge clk); n++; end
        if (to_tx) begin
            check(tx_valid && !svc_req, "R8", "console write routed to tx", {svc_req, tx_valid}, 1);
            check(tx_data == wbyte, "R8", "tx_data", tx_data, wbyte);
            ok = 1'b1;
            for (int i = 0; i < delay; i++) begin
                @(negedge clk);
                if (wait_n || !tx_valid || tx_data != wbyte) ok = 1'b0;
            end
            check(ok, "R8", "wait low while tx busy", wait_n, 0);
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            check(wait_n && !tx_valid, "R8", "release after tx accept", {wait_n, tx_valid}, 2);
        end else begin
            check(svc_req && !tx_valid, "R4", "request to service side", {svc_req, tx_valid}, 2);
            if (!is_wr && port == AW'(4))
                check(!tx_valid, "R10", "console read not on tx", tx_valid, 0);
            check(svc_port == port, "R4", "svc_port", svc_port, port);
            check(svc_write == is_wr, "R4", "svc_write", svc_write, is_wr);
            if (is_wr) check(svc_wdata == wbyte, "R4", "svc_wdata", svc_wdata, wbyte);
            check(reload_req == is_reload(is_wr, port), "R9", "reload on first req cycle",
                  reload_req, is_reload(is_wr, port));
            ok = 1'b1;
            for (int i = 0; i < delay; i++) begin
                @(negedge clk);
                if (wait_n || !svc_req || svc_port != port) ok = 1'b0;
                if (reload_req) ok = 1'b0;
            end
            check(ok, "R3", "wait and request held until ack", wait_n, 0);
            svc_ack = 1'b1; svc_rdata = rbyte;
            @(negedge clk);
            svc_ack = 1'b0; svc_rdata = ~rbyte;
            check(wait_n && !svc_req, "R5", "release after ack", {wait_n, svc_req}, 2);
            check(!reload_req, "R9", "reload is one cycle", reload_req, 0);
            if (!is_wr) begin
                check(data_oe && data_out == rbyte, "R6", "read byte driven", data_out, rbyte);
            end else begin
                check(!data_oe, "R6", "no drive on write", data_oe, 0);
            end
        end
        // R7: no second request while iorq stays low
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (svc_req || tx_valid || !wait_n) ok = 1'b0;
            if (!is_wr && !data_oe) ok = 1'b0;
        end
        check(ok, "R7", "single request per cycle", {svc_req, tx_valid}, 0);
        iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        n = 0;
        while (data_oe && n < 8) begin @(negedge clk); n++; end
        check(!data_oe && wait_n, "R6", "drive off after iorq high", data_oe, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unused;
        bit okc;
        logic prev;
        unused = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1
        check(wait_n && !cpu_clk && !svc_req && !tx_valid && !data_oe && !reload_req,
              "R1", "reset state", {wait_n, cpu_clk, svc_req, tx_valid, data_oe, reload_req}, 32);
        rst_n = 1'b1;
        @(negedge clk);
        // R2
        okc = 1'b1;
        prev = cpu_clk;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cpu_clk == prev) okc = 1'b0;
            prev = cpu_clk;
        end
        check(okc, "R2", "cpu_clk toggles each clk", cpu_clk, ~prev);

        io_cycle(1'b0, 8'h10, 8'h00, 0, 8'hA5);
        io_cycle(1'b1, 8'h22, 8'h3C, 3, 8'h00);
        io_cycle(1'b1, 8'h04, 8'h41, 0, 8'h00);
        io_cycle(1'b1, 8'h04, 8'h42, 5, 8'h00);
        io_cycle(1'b0, 8'h04, 8'h00, 2, 8'h5A);
        io_cycle(1'b1, 8'h01, 8'h07, 1, 8'h00);
        io_cycle(1'b0, 8'h01, 8'h00, 0, 8'hFF);

        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] p;
            int sel = $urandom_range(0, 3);
            p = (sel == 0) ? AW'(4) : (sel == 1) ? AW'(1) : AW'($urandom_range(0, 255));
            io_cycle(bit'($urandom_range(0, 1)), p, DW'($urandom_range(0, 255)),
                     $urandom_range(0, 5), DW'($urandom_range(0, 255)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule